// File: doc/BRIEF.md
# Serial Gamepad Poller

This block reads a shift-register style game controller that has no clock of its own. On a start request it raises a latch line so that the controller captures its buttons. It then drives a train of clock pulses and takes in one button bit per pulse. The controller line idles high and reads low for a pressed button. The block inverts each bit, so the result is an active-high button word.

A typical host pulses the start input once per video frame. It takes the button word when the one-cycle done flag appears. The word holds its value between polls and changes only when a whole set of bits has been captured. The pulse timing comes from a divider parameter, so the same block serves any system clock.

Top module: `pad_poller`

## Requirements
- R1: While reset is active, and after it is released, the latch line, the controller clock and the done flag are low, and the button word is all zeros.
- R2: A start request seen while the block is idle raises the latch line on the next cycle. The latch stays high for exactly 2*HALF_TICKS cycles. The controller clock stays low throughout.
- R3: Exactly NUM_BITS clock pulses follow the latch. Each pulse is a low half of HALF_TICKS cycles followed by a high half of HALF_TICKS cycles, with no gap between pulses.
- R4: The latch line and the controller clock are never high in the same cycle. Neither is high in a cycle where done is high.
- R5: The data line is sampled once per pulse, at the end of the low half. The first bit, which is valid right after the latch falls, lands in word bit 0, and each later bit takes the next higher position. A low data level reads as 1 (pressed).
- R6: Done is high for exactly one cycle, 2*HALF_TICKS + 2*NUM_BITS*HALF_TICKS cycles after the latch rose. The button word changes only in that cycle.
- R7: A start request that arrives while a poll is running is ignored. No new latch pulse is produced and the poll timing is unchanged. A start request in the cycle that done is high begins a new poll.
- R8: The word reports the buttons that the controller captured at the latch edge. A change at the buttons after the latch does not alter that poll's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_start | input | 1 | Request to start one poll |
| pad_data | input | 1 | Serial button data from the controller, low means pressed |
| pad_latch | output | 1 | Latch pulse to the controller |
| pad_clk | output | 1 | Shift clock to the controller |
| buttons | output | NUM_BITS | Active-high button word, bit 0 shifted in first |
| poll_done | output | 1 | One-cycle flag marking a new button word |

## Verification
The bench builds the block with HALF_TICKS = 4, NUM_BITS = 16 and SYNC_STAGES = 2. With these values one poll takes 136 cycles instead of over twenty thousand. That keeps back-to-back polls, start requests in the middle of a poll and a start held high through the done cycle within a short run. The half-period of four cycles still exceeds the synchronizer depth. As a result, the exact end-of-low-half sampling point is exercised against data that changes on each rising shift edge.

// File: rtl/pad_pkg.sv
package pad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LATCH = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } poll_state_e;

endpackage

// File: rtl/pad_rst_sync.sv
module pad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = d_in;
    end else begin : g_multi
      always_comb stage_d = {stage_q[STAGES-2:0], d_in};
    end
  endgenerate

  // data line idles high, so the chain resets to high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/pad_seq.sv
module pad_seq
  import pad_pkg::*;
#(
  parameter int HALF_TICKS = 600,
  parameter int NUM_BITS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic latch_o,
  output logic pclk_o,
  output logic sample_o,
  output logic finish_o
);

  localparam int CNT_W = $clog2(2 * HALF_TICKS);
  localparam int BIT_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
  localparam logic [CNT_W-1:0] LATCH_LAST = CNT_W'(2 * HALF_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(HALF_TICKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(NUM_BITS - 1);

  poll_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             cnt_en, bit_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q + 1'b1;
    bit_d    = bit_q;
    cnt_en   = 1'b0;
    bit_en   = 1'b0;
    sample_o = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LATCH;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_LATCH: begin
        cnt_en = 1'b1;
        if (cnt_q == LATCH_LAST) begin
          state_d = ST_LOW;
          cnt_d   = '0;
          bit_d   = '0;
          bit_en  = 1'b1;
        end
      end
      ST_LOW: begin
        cnt_en = 1'b1;
        if (cnt_q == HALF_LAST) begin
          sample_o = 1'b1;
          state_d  = ST_HIGH;
          cnt_d    = '0;
        end
      end
      ST_HIGH: begin
        cnt_en = 1'b1;
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          if (bit_q == BIT_LAST) begin
            finish_o = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            bit_d   = bit_q + 1'b1;
            bit_en  = 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (bit_en) bit_q <= bit_d;
    end
  end

  assign latch_o = (state_q == ST_LATCH);
  assign pclk_o  = (state_q == ST_HIGH);

  // R4
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_o && pclk_o));

  // R2
  latch_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_o) |-> $past(start_i));

  // R7
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> !$rose(latch_o));

  // R3
  pulse_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_o) |-> (state_q == ST_LOW || state_q == ST_IDLE));

endmodule

// File: rtl/pad_capture.sv
module pad_capture #(
  parameter int NUM_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_i,
  input  logic                finish_i,
  input  logic                data_i,
  output logic [NUM_BITS-1:0] word_o,
  output logic                done_o
);

  logic [NUM_BITS-1:0] shift_q, shift_d;
  logic [NUM_BITS-1:0] word_q;
  logic                done_q;

  generate
    if (NUM_BITS == 1) begin : g_one
      always_comb shift_d = ~data_i;
    end else begin : g_many
      // first bit enters at the top and walks down to bit 0
      always_comb shift_d = {~data_i, shift_q[NUM_BITS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      if (sample_i) shift_q <= shift_d;
      if (finish_i) word_q  <= shift_q;
      done_q <= finish_i;
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

  // R6
  word_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q != $past(word_q)) |-> done_q);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/pad_poller.sv
module pad_poller #(
  parameter int HALF_TICKS  = 600,
  parameter int NUM_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll_start,
  input  logic                pad_data,
  output logic                pad_latch,
  output logic                pad_clk,
  output logic [NUM_BITS-1:0] buttons,
  output logic                poll_done
);

  logic rst_n_int;
  logic data_sync;
  logic sample_en;
  logic finish;

  pad_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_in  (pad_data),
    .d_out (data_sync)
  );

  pad_seq #(.HALF_TICKS(HALF_TICKS), .NUM_BITS(NUM_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (poll_start),
    .latch_o  (pad_latch),
    .pclk_o   (pad_clk),
    .sample_o (sample_en),
    .finish_o (finish)
  );

  pad_capture #(.NUM_BITS(NUM_BITS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sample_i (sample_en),
    .finish_i (finish),
    .data_i   (data_sync),
    .word_o   (buttons),
    .done_o   (poll_done)
  );

  // R4
  out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({pad_latch, pad_clk, poll_done}));

endmodule

// File: tb/sim_pad_poller.sv
module sim_pad_poller;

  localparam int H    = 4;
  localparam int NB   = 16;
  localparam int POLL = 2 * H + 2 * NB * H;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          poll_start = 1'b0;
  logic          pad_data;
  logic          pad_latch, pad_clk, poll_done;
  logic [NB-1:0] buttons;

  int checks = 0;
  int errors = 0;

  pad_poller #(.HALF_TICKS(H), .NUM_BITS(NB), .SYNC_STAGES(2)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .poll_start (poll_start),
    .pad_data   (pad_data),
    .pad_latch  (pad_latch),
    .pad_clk    (pad_clk),
    .buttons    (buttons),
    .poll_done  (poll_done)
  );

  always #5 clk = ~clk;

  // controller model
  logic [NB-1:0] pressed = '0;
  logic [NB-1:0] snap = '0;
  int            idx = NB;
  int            latch_rises = 0;

  always @(posedge pad_latch) begin
    snap = pressed;
    idx  = 0;
    latch_rises++;
  end
  always @(posedge pad_clk) idx = idx + 1;
  always_comb pad_data = (idx < NB) ? ~snap[idx] : 1'b1;

  // reference timeline
  int            ofs = -1;
  logic          exp_done = 1'b0;
  logic [NB-1:0] exp_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ofs = -1; exp_done = 1'b0; exp_word = '0;
    end else begin
      exp_done = 1'b0;
      if (ofs < 0) begin
        if (poll_start) ofs = 0;
      end else begin
        ofs = ofs + 1;
        if (ofs == POLL) begin
          exp_done = 1'b1;
          exp_word = snap;
          ofs = -1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  logic cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 latch", 32'(pad_latch), 32'(ofs >= 0 && ofs < 2 * H));
      chk("R3 pulse", 32'(pad_clk), 32'(ofs >= 2 * H && ((ofs - 2 * H) % (2 * H)) >= H));
      chk("R6 done", 32'(poll_done), 32'(exp_done));
      chk("R5 word", 32'(buttons), 32'(exp_word));
      chk("R4 overlap", 32'(pad_latch & (pad_clk | poll_done)), 32'd0);
    end
  end

  task automatic poll(input logic [NB-1:0] pat, input string req);
    pressed = pat;
    @(negedge clk) poll_start = 1'b1;
    @(negedge clk) poll_start = 1'b0;
    repeat (POLL + 3) @(negedge clk);
    chk(req, 32'(buttons), 32'(pat));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rises;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset", 32'({pad_latch, pad_clk, poll_done, buttons}), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after release", 32'({pad_latch, pad_clk, poll_done, buttons}), 32'd0);
    cmp_en = 1'b1;

    poll(16'h0000, "R5 none pressed");
    poll(16'hFFFF, "R5 all pressed");
    poll(16'h0001, "R5 first bit");
    poll(16'h8000, "R5 last bit");
    poll(16'hA5C3, "R5 mixed");

    // R7: start pulses during a running poll
    rises = latch_rises;
    pressed = 16'h3C5A;
    @(negedge clk) poll_start = 1'b1;
    @(negedge clk) poll_start = 1'b0;
    repeat (H) @(negedge clk);
    poll_start = 1'b1;
    @(negedge clk) poll_start = 1'b0;
    repeat (POLL / 2) @(negedge clk);
    poll_start = 1'b1;
    @(negedge clk) poll_start = 1'b0;
    repeat (POLL) @(negedge clk);
    chk("R7 single latch", 32'(latch_rises - rises), 32'd1);
    chk("R7 word", 32'(buttons), 32'h3C5A);

    // R8: buttons change after the latch edge
    pressed = 16'h1234;
    @(negedge clk) poll_start = 1'b1;
    @(negedge clk) poll_start = 1'b0;
    repeat (3 * H) @(negedge clk);
    pressed = 16'hFEDC;
    repeat (POLL) @(negedge clk);
    chk("R8 snapshot", 32'(buttons), 32'h1234);

    // R7: start held high gives back-to-back polls
    rises = latch_rises;
    pressed = 16'h0F0F;
    @(negedge clk) poll_start = 1'b1;
    repeat (2 * POLL + 4) @(negedge clk);
    poll_start = 1'b0;
    repeat (POLL + 4) @(negedge clk);
    chk("R7 back-to-back", 32'(latch_rises - rises), 32'd3);
    chk("R5 back-to-back word", 32'(buttons), 32'h0F0F);

    cmp_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule